// File: doc/BRIEF.md
# Vector Saturating Dword-to-Word Packer

This block narrows signed 32-bit integers taken from two vector sources into unsigned 16-bit integers. Each value is clamped to the range 0 to 0xFFFF. The register width is 512 bits. The active length can be one, two or four 128-bit lanes. Within every active lane, the low four result words come from the first source and the high four come from the second source.

Three operating modes decide how the destination is written:

- **Legacy mode** reads its first source from the old destination. It leaves every destination bit above the first lane untouched.
- **Short modern mode** clears all destination bits above the active length.
- **Extended mode** also clears those bits. It adds two features: per-word write masking, which either merges old destination words or zeroes them, and broadcast of the lowest dword of the second source.

Operations enter through a valid/ready input. The input is ready whenever the one-entry output register is empty, or is being drained in the same cycle. The result is held steady on the output until the consumer takes it.

Top module: `vpk_packer`

## Requirements
- R1: A source dword whose bit 31 is set gives the word 0x0000. A non-negative dword above 0xFFFF gives 0xFFFF. Any other dword gives its own low 16 bits.
- R2: In lane L (bits 128L+127 down to 128L), result word W (bits 16W+15 down to 16W within the lane) comes from the first source for W = 0..3, using dword W of that lane. For W = 4..7 it comes from the second source, using dword W-4 of that lane.
- R3: `mode` is encoded as 0 = legacy, 1 = short modern, 2 = extended, 3 = treated as short modern. `vlen` is encoded as 0 = 128 bits, 1 = 256 bits, 2 = 512 bits, 3 = 128 bits. Legacy mode always runs at 128 bits. A length of 512 is honoured only in extended mode; any other mode runs at 128 bits instead.
- R4: In extended mode with both `bcast` and `b_is_mem` high, every dword of the second source is replaced by `src_b[31:0]`. Either flag alone has no effect.
- R5: In extended mode with `use_mask` high and `zero_mode` low, an active word k whose `wmask[k]` is 0 keeps `dst_old` word k.
- R6: In extended mode with `use_mask` and `zero_mode` both high, an active word k whose `wmask[k]` is 0 becomes 0x0000.
- R7: With `use_mask` low, or in any non-extended mode, `wmask` and `zero_mode` are ignored. Outside extended mode, `bcast` is ignored as well.
- R8: In non-legacy modes, all result bits above the active length are 0.
- R9: In legacy mode, `dst_old[127:0]` replaces `src_a` as the first source, `src_a` is ignored, and `result[511:128]` equals `dst_old[511:128]`.
- R10: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. An operation accepted on a clock edge appears on `result` with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, `result` and `out_valid` hold.
- R11: Synchronous reset clears `out_valid` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block can accept an operation |
| src_a | input | 512 | First source dwords (unused in legacy mode) |
| src_b | input | 512 | Second source dwords |
| dst_old | input | 512 | Previous destination contents |
| wmask | input | 32 | Per-word write mask, bit k for result word k |
| mode | input | 2 | Operating mode (R3) |
| vlen | input | 2 | Vector length code (R3) |
| bcast | input | 1 | Broadcast request for the second source |
| b_is_mem | input | 1 | The second source is a memory operand |
| use_mask | input | 1 | Write masking enabled |
| zero_mode | input | 1 | Masked words are zeroed rather than merged |
| out_valid | output | 1 | `result` holds an untaken operation |
| out_ready | input | 1 | The consumer takes the result |
| result | output | 512 | Packed destination value |

## Verification
The assertions assume that the operand and control pins are stable and meaningful on every cycle in which `in_valid` is high. They also assume that `out_ready` is a defined level at each clock edge. The bench changes its inputs only shortly after a rising edge. It holds an offered operation unchanged until it sees `in_ready` high, and it drives `out_ready` as a clean level, either constant or randomly chosen once per cycle. Operand dwords are drawn from classes that reach both clamp boundaries, the values next to them, and both extremes of the signed range.

// File: rtl/vpk_pkg.sv
`timescale 1ns/1ps
package vpk_pkg;
  localparam int DW_W = 32;
  localparam int HW_W = 16;

  typedef enum logic [1:0] {
    VPK_LEGACY = 2'd0,
    VPK_SHORT  = 2'd1,
    VPK_EXT    = 2'd2,
    VPK_RSVD   = 2'd3
  } vpk_mode_e;

  function automatic logic [HW_W-1:0] clamp_u16(input logic [DW_W-1:0] v);
    if (v[DW_W-1])
      return '0;
    else if (|v[DW_W-2:HW_W])
      return '1;
    else
      return v[HW_W-1:0];
  endfunction
endpackage

// File: rtl/vpk_sat.sv
`timescale 1ns/1ps
module vpk_sat
  import vpk_pkg::*;
(
  input  logic [DW_W-1:0] din,
  output logic [HW_W-1:0] dout
);
  assign dout = clamp_u16(din);
endmodule

// File: rtl/vpk_lane.sv
`timescale 1ns/1ps
module vpk_lane
  import vpk_pkg::*;
#(
  parameter int LANE_BITS = 128
) (
  input  logic [LANE_BITS-1:0] lo_src,
  input  logic [LANE_BITS-1:0] hi_src,
  output logic [LANE_BITS-1:0] packed_o
);
  localparam int DWS = LANE_BITS / DW_W;
  localparam int HALF_BITS = LANE_BITS / 2;

  for (genvar i = 0; i < DWS; i++) begin : g_dw
    // low half of the lane from the first source, high half from the second
    vpk_sat u_lo (
      .din  (lo_src[i*DW_W +: DW_W]),
      .dout (packed_o[i*HW_W +: HW_W])
    );
    vpk_sat u_hi (
      .din  (hi_src[i*DW_W +: DW_W]),
      .dout (packed_o[HALF_BITS + i*HW_W +: HW_W])
    );
  end
endmodule

// File: rtl/vpk_ctrl.sv
`timescale 1ns/1ps
module vpk_ctrl
  import vpk_pkg::*;
#(
  parameter int LANES = 4,
  parameter int WORDS = 32
) (
  input  logic [1:0]       mode,
  input  logic [1:0]       vlen,
  input  logic             bcast,
  input  logic             b_is_mem,
  input  logic             use_mask,
  input  logic [WORDS-1:0] wmask,
  output logic [LANES-1:0] lane_on,
  output logic             legacy,
  output logic             splat_b,
  output logic [WORDS-1:0] take
);
  vpk_mode_e mode_e;
  logic      ext;
  int        n_on;

  assign mode_e  = vpk_mode_e'(mode);
  assign legacy  = (mode_e == VPK_LEGACY);
  assign ext     = (mode_e == VPK_EXT);
  assign splat_b = ext && bcast && b_is_mem;

  always_comb begin
    n_on = 1;
    if (!legacy && vlen == 2'd1) n_on = 2;
    if (ext && vlen == 2'd2)     n_on = 4;
    if (n_on > LANES)            n_on = LANES;
    for (int l = 0; l < LANES; l++) lane_on[l] = (l < n_on);
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_take
    assign take[k] = !(ext && use_mask) || wmask[k];
  end
endmodule

// File: rtl/vpk_packer.sv
`timescale 1ns/1ps
module vpk_packer
  import vpk_pkg::*;
#(
  parameter int MAX_BITS  = 512,
  parameter int LANE_BITS = 128
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [MAX_BITS-1:0]   src_a,
  input  logic [MAX_BITS-1:0]   src_b,
  input  logic [MAX_BITS-1:0]   dst_old,
  input  logic [MAX_BITS/16-1:0] wmask,
  input  logic [1:0]            mode,
  input  logic [1:0]            vlen,
  input  logic                  bcast,
  input  logic                  b_is_mem,
  input  logic                  use_mask,
  input  logic                  zero_mode,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [MAX_BITS-1:0]   result
);
  localparam int LANES  = MAX_BITS / LANE_BITS;
  localparam int WORDS  = MAX_BITS / HW_W;
  localparam int WPL    = LANE_BITS / HW_W;
  localparam int DWORDS = MAX_BITS / DW_W;

  logic [LANES-1:0]    lane_on;
  logic                legacy, splat_b;
  logic [WORDS-1:0]    take;
  logic [MAX_BITS-1:0] first_src, second_src, packed_all, next_res;
  logic                fire;

  vpk_ctrl #(.LANES(LANES), .WORDS(WORDS)) u_ctrl (
    .mode     (mode),
    .vlen     (vlen),
    .bcast    (bcast),
    .b_is_mem (b_is_mem),
    .use_mask (use_mask),
    .wmask    (wmask),
    .lane_on  (lane_on),
    .legacy   (legacy),
    .splat_b  (splat_b),
    .take     (take)
  );

  assign first_src = legacy ? dst_old : src_a;

  for (genvar d = 0; d < DWORDS; d++) begin : g_bsrc
    assign second_src[d*DW_W +: DW_W] = splat_b ? src_b[DW_W-1:0] : src_b[d*DW_W +: DW_W];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vpk_lane #(.LANE_BITS(LANE_BITS)) u_lane (
      .lo_src   (first_src[l*LANE_BITS +: LANE_BITS]),
      .hi_src   (second_src[l*LANE_BITS +: LANE_BITS]),
      .packed_o (packed_all[l*LANE_BITS +: LANE_BITS])
    );
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    localparam int LN = k / WPL;
    always_comb begin
      if (lane_on[LN]) begin
        if (take[k])        next_res[k*HW_W +: HW_W] = packed_all[k*HW_W +: HW_W];
        else if (zero_mode) next_res[k*HW_W +: HW_W] = '0;
        else                next_res[k*HW_W +: HW_W] = dst_old[k*HW_W +: HW_W];
      end else begin
        next_res[k*HW_W +: HW_W] = legacy ? dst_old[k*HW_W +: HW_W] : '0;
      end
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      result    <= next_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1: negative and overflowing dwords clamp to the boundaries
  p_neg_clamp_r1: assert property (@(posedge clk) disable iff (rst)
    fire && mode == 2'd1 && src_a[31] |=> result[15:0] == 16'h0000);
  p_big_clamp_r1: assert property (@(posedge clk) disable iff (rst)
    fire && mode == 2'd1 && !src_a[31] && (|src_a[30:16]) |=> result[15:0] == 16'hFFFF);
  // R2: word 4 of lane 0 comes from dword 0 of the second source
  p_hi_half_r2: assert property (@(posedge clk) disable iff (rst)
    fire && mode == 2'd1 && src_b[31:16] == 16'h0 |=> result[79:64] == $past(src_b[15:0]));
  // R3: a 512-bit request in short modern mode runs at 128 bits
  p_len_clip_r3: assert property (@(posedge clk) disable iff (rst)
    fire && mode == 2'd1 && vlen == 2'd2 |=> result[MAX_BITS-1:128] == '0);
  // R4: broadcast copies dword 0 into the second half of lane 0
  p_splat_r4: assert property (@(posedge clk) disable iff (rst)
    fire && mode == 2'd2 && bcast && b_is_mem && !use_mask && src_b[31:16] == 16'h0
    |=> result[79:64] == $past(src_b[15:0]) && result[95:80] == $past(src_b[15:0]));
  // R5: merge masking keeps the old word
  p_merge_r5: assert property (@(posedge clk) disable iff (rst)
    fire && mode == 2'd2 && use_mask && !zero_mode && !wmask[0]
    |=> result[15:0] == $past(dst_old[15:0]));
  // R6: zero masking clears the word
  p_zero_r6: assert property (@(posedge clk) disable iff (rst)
    fire && mode == 2'd2 && use_mask && zero_mode && !wmask[0] |=> result[15:0] == 16'h0000);
  // R8: upper bits cleared at 128-bit length in modern modes
  p_upper_clear_r8: assert property (@(posedge clk) disable iff (rst)
    fire && mode != 2'd0 && vlen == 2'd0 |=> result[MAX_BITS-1:128] == '0);
  // R9: legacy keeps the destination above the first lane
  p_legacy_keep_r9: assert property (@(posedge clk) disable iff (rst)
    fire && mode == 2'd0 |=> result[MAX_BITS-1:128] == $past(dst_old[MAX_BITS-1:128]));
  // R10: a stalled result holds and blocks new input
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(result));
  p_block_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);
  // R11: reset empties the output
  p_reset_r11: assert property (@(posedge clk)
    $past(rst) |-> !out_valid && result == '0);
endmodule

// File: tb/tb_vpk_packer.sv
`timescale 1ns/1ps
module tb_vpk_packer;
  logic         clk = 0;
  logic         rst = 1;
  logic         in_valid = 0;
  logic         in_ready;
  logic [511:0] src_a = '0, src_b = '0, dst_old = '0;
  logic [31:0]  wmask = '0;
  logic [1:0]   mode = 0, vlen = 0;
  logic         bcast = 0, b_is_mem = 0, use_mask = 0, zero_mode = 0;
  logic         out_valid;
  logic         out_ready = 1;
  logic [511:0] result;

  int checks = 0;
  int errors = 0;
  bit rand_ready = 0;
  bit done = 0;

  logic [511:0] exp_q[$];
  string        tag_q[$];

  always #10 clk = ~clk;

  vpk_packer dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old), .wmask(wmask),
    .mode(mode), .vlen(vlen), .bcast(bcast), .b_is_mem(b_is_mem),
    .use_mask(use_mask), .zero_mode(zero_mode), .out_valid(out_valid),
    .out_ready(out_ready), .result(result)
  );

  function automatic logic [511:0] model(
    input logic [511:0] a, input logic [511:0] b, input logic [511:0] d,
    input logic [31:0] m, input logic [1:0] md, input logic [1:0] vl,
    input logic bc, input logic mem, input logic um, input logic zm);
    logic [511:0] r;
    logic [31:0]  v;
    logic [15:0]  p;
    int nw, lane, w, idx;
    bit ext, leg;
    ext = (md == 2);
    leg = (md == 0);
    nw = 8;
    if (!leg && vl == 1) nw = 16;
    if (ext && vl == 2)  nw = 32;
    for (int k = 0; k < 32; k++) begin
      if (k >= nw) begin
        r[k*16 +: 16] = leg ? d[k*16 +: 16] : 16'h0;
      end else begin
        lane = k / 8;
        w    = k % 8;
        idx  = lane * 4 + (w % 4);
        if (w < 4) v = leg ? d[idx*32 +: 32] : a[idx*32 +: 32];
        else       v = (ext && bc && mem) ? b[31:0] : b[idx*32 +: 32];
        if ($signed(v) < 0)           p = 16'h0000;
        else if ($signed(v) > 65535)  p = 16'hFFFF;
        else                          p = v[15:0];
        if (ext && um && !m[k]) p = zm ? 16'h0 : d[k*16 +: 16];
        r[k*16 +: 16] = p;
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] pick_dw();
    case ($urandom % 5)
      0: return $urandom | 32'h8000_0000;
      1: return $urandom % 65536;
      2: return 32'h0001_0000 + ($urandom % 32'h7FFE_FFFF);
      3: case ($urandom % 6)
           0: return 32'h0000_0000;
           1: return 32'h0000_FFFF;
           2: return 32'h0001_0000;
           3: return 32'hFFFF_FFFF;
           4: return 32'h7FFF_FFFF;
           default: return 32'h8000_0000;
         endcase
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [511:0] pick_vec();
    logic [511:0] x;
    for (int i = 0; i < 16; i++) x[i*32 +: 32] = pick_dw();
    return x;
  endfunction

  task automatic send(input string tag, input logic [511:0] a, input logic [511:0] b,
                      input logic [511:0] d, input logic [31:0] m, input logic [1:0] md,
                      input logic [1:0] vl, input logic bc, input logic mem,
                      input logic um, input logic zm);
    src_a = a; src_b = b; dst_old = d; wmask = m; mode = md; vlen = vl;
    bcast = bc; b_is_mem = mem; use_mask = um; zero_mode = zm;
    in_valid = 1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    exp_q.push_back(model(a, b, d, m, md, vl, bc, mem, um, zm));
    tag_q.push_back(tag);
    @(posedge clk);
    #2 in_valid = 0;
  endtask

  // out_ready driver
  always @(posedge clk) begin
    if (rand_ready) #2 out_ready = ($urandom % 3) != 0;
  end

  // monitor
  bit           prev_stall = 0;
  logic [511:0] prev_res;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        checks++;
        if (!(out_valid && result == prev_res)) begin
          errors++;
          $display("FAIL R10 hold: valid=%0b result=%h expected %h", out_valid, result, prev_res);
        end
      end
      if (out_valid && !out_ready) begin
        checks++;
        if (in_ready) begin
          errors++;
          $display("FAIL R10 in_ready=%0b expected 0 while stalled", in_ready);
        end
      end
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected output %h expected none", result);
        end else begin
          logic [511:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (result !== e) begin
            errors++;
            $display("FAIL %s: result=%h expected=%h", t, result, e);
          end
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_res   = result;
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [511:0] a, b, d;
    repeat (3) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    // R11 reset state
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11: valid=%0b ready=%0b result=%h expected 0/1/0", out_valid, in_ready, result);
    end
    @(posedge clk); #2;

    d = {16{32'hA5A5_5A5A}};
    a = '0; b = '0;
    a[127:0] = {32'h0000_1234, 32'h0000_FFFF, 32'h0001_0000, 32'hFFFF_FFFF};
    b[127:0] = {32'h0000_0001, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0000};
    send("R1 R2 clamp and order", a, b, d, 32'h0, 2'd1, 2'd0, 0, 0, 0, 0);
    send("R3 R8 short 256", pick_vec(), pick_vec(), d, 32'h0, 2'd1, 2'd1, 0, 0, 0, 0);
    send("R3 short 512 clipped", pick_vec(), pick_vec(), d, 32'h0, 2'd1, 2'd2, 0, 0, 0, 0);
    send("R3 vlen 3 at 128", pick_vec(), pick_vec(), d, 32'h0, 2'd2, 2'd3, 0, 0, 0, 0);
    send("R3 mode 3 as short", pick_vec(), pick_vec(), d, 32'h0, 2'd3, 2'd1, 1, 1, 1, 1);
    send("R3 extended 512", pick_vec(), pick_vec(), d, 32'h0, 2'd2, 2'd2, 0, 0, 0, 0);
    b = pick_vec(); b[31:0] = 32'h0000_BEEF;
    send("R4 broadcast", pick_vec(), b, d, 32'h0, 2'd2, 2'd2, 1, 1, 0, 0);
    send("R4 bcast without mem", pick_vec(), b, d, 32'h0, 2'd2, 2'd2, 1, 0, 0, 0);
    send("R5 merge mask", pick_vec(), pick_vec(), d, 32'h5A5A_0F0F, 2'd2, 2'd2, 0, 0, 1, 0);
    send("R6 zero mask", pick_vec(), pick_vec(), d, 32'hF0F0_3C3C, 2'd2, 2'd1, 0, 0, 1, 1);
    send("R7 mask off", pick_vec(), pick_vec(), d, 32'h0, 2'd2, 2'd2, 0, 0, 0, 1);
    send("R7 short ignores mask", pick_vec(), b, d, 32'h0, 2'd1, 2'd1, 1, 1, 1, 1);
    send("R9 legacy", pick_vec(), pick_vec(), pick_vec(), 32'h0, 2'd0, 2'd0, 0, 0, 0, 0);
    send("R9 R3 legacy long", pick_vec(), pick_vec(), pick_vec(), 32'h0, 2'd0, 2'd2, 1, 1, 1, 1);

    // R10 back-pressure
    out_ready = 0;
    fork
      send("R10 stalled a", pick_vec(), pick_vec(), d, 32'h0, 2'd1, 2'd1, 0, 0, 0, 0);
      begin repeat (5) @(posedge clk); #2 out_ready = 1; end
    join
    send("R10 follow", pick_vec(), pick_vec(), d, 32'h0, 2'd2, 2'd2, 0, 0, 0, 0);

    // random traffic with random back-pressure
    rand_ready = 1;
    for (int n = 0; n < 300; n++) begin
      send("R1 R2 R4 R5 R6 R8 R9 random", pick_vec(), pick_vec(), pick_vec(), $urandom,
           2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    rand_ready = 0;
    @(posedge clk); #2 out_ready = 1;
    while (exp_q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule